// File: doc/BRIEF.md
# Transceiver Status Aggregation Register

This block is a read-only status word in a management register file. It collects event flags and level conditions from several transceiver sub-blocks into one 16-bit word, so that software can poll link health with a single read. Five of its bits are sticky. A one-cycle pulse from the sub-block that owns the event sets the bit. The bit is cleared only when software reads the register that owns that event, such as an error counter, an expansion register or an interrupt status register. Reading the aggregate word itself never disturbs any of them.

The block also qualifies the 100 Mb/s signal-detect that feeds the link monitor. When the qualify control is high, the raw detect is ANDed with descrambler lock. When the control is low, the raw detect passes through unchanged. The qualified detect is a port of its own, and the aggregate word also reports it. The register decoder supplies one read strobe per owning register, plus one strobe for the aggregate word. On a strobe for the aggregate word, the block captures the word into its read-data register.

Top module: `xcvr_status_agg`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0 and every sticky bit is 0, so the first aggregate read returns 0 when all level inputs are low.
- R2: A pulse on `rx_err_evt` sets the receive-error bit (bit 6). Only `rd_rxerr_cnt` clears it.
- R3: A pulse on `false_carr_evt` sets the false-carrier bit (bit 7). Only `rd_fcar_cnt` clears it.
- R4: A pulse on `pol_inv_evt` sets the inverted-polarity bit (bit 5). Only `rd_tenbt_stat` clears it.
- R5: A pulse on `page_rx_evt` sets the page-received bit (bit 4). Only `rd_an_exp` clears it.
- R6: A pulse on `irq_evt` sets the interrupt-pending bit (bit 3). Only `rd_irq_stat` clears it.
- R7: An aggregate read (`rd_agg`) clears none of the sticky bits, and a strobe that belongs to a different register leaves a sticky bit set.
- R8: When an event pulse and its owner's clearing read fall in the same cycle, the sticky bit ends up set.
- R9: An aggregate read in the same cycle as a clearing read returns the bit as it was before the clear. The next aggregate read returns 0.
- R10: `sigdet_q` equals `raw_sd & descr_lock` when `sd_qual_en` is 1, and equals `raw_sd` when `sd_qual_en` is 0. Bit 0 of the captured word reports it.
- R11: Bit 1 of the captured word reports `descr_lock`. Bit 2 reports `mdix_swapped` (1 = pairs swapped, 0 = normal).
- R12: Bits 15:8 of `rd_data` always read 0.
- R13: `rd_data` changes only on a cycle with `rd_agg` high. It then holds the word as it stood in that cycle, before that edge's latch updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_err_evt | input | 1 | Receive-error event pulse |
| false_carr_evt | input | 1 | False-carrier event pulse |
| pol_inv_evt | input | 1 | Inverted-polarity detected pulse |
| page_rx_evt | input | 1 | Auto-negotiation page received pulse |
| irq_evt | input | 1 | Internal interrupt raised pulse |
| rd_rxerr_cnt | input | 1 | Read strobe, receive-error counter register |
| rd_fcar_cnt | input | 1 | Read strobe, false-carrier counter register |
| rd_tenbt_stat | input | 1 | Read strobe, 10BASE-T status register |
| rd_an_exp | input | 1 | Read strobe, auto-negotiation expansion register |
| rd_irq_stat | input | 1 | Read strobe, interrupt status register |
| rd_agg | input | 1 | Read strobe, this aggregate register |
| raw_sd | input | 1 | Raw signal-detect from the medium side |
| descr_lock | input | 1 | Descrambler lock level |
| sd_qual_en | input | 1 | 1 = qualify detect with descrambler lock |
| mdix_swapped | input | 1 | Crossover state from the crossover logic |
| sigdet_q | output | 1 | Qualified signal-detect |
| rd_data | output | 16 | Captured aggregate word |

## Verification
The assertions watch every cycle for the following:
- each sticky bit is set after a pulse;
- a bit falls after its owner's read when no new event arrives;
- a bit holds when neither an event nor its clearing read is present;
- the captured word only moves on an aggregate read;
- the reserved bits stay zero;
- the detect is never high without raw detect, or without lock while qualifying.

Only the bench's scenarios show the following:
- which particular strobe clears which particular bit;
- that the captured word carries the bit positions that software decodes;
- that a simultaneous aggregate read and clearing read return the pre-clear value, and the following read returns the cleared one.

// File: rtl/xstat_pkg.sv
// Package: shared constants and the packed field layout of the aggregate status word.
// Assumes the word is at least USED_BITS wide; upper bits are reserved and read as zero.
package xstat_pkg;
    localparam int NUM_LATCH = 5;
    localparam int USED_BITS = 8;

    // Sticky-latch index order inside the event/clear vectors
    localparam int LAT_RXERR = 0;
    localparam int LAT_FCAR  = 1;
    localparam int LAT_POL   = 2;
    localparam int LAT_PAGE  = 3;
    localparam int LAT_IRQ   = 4;

    // Bit positions in the aggregate word (software decodes these)
    localparam int BIT_SDQ   = 0;
    localparam int BIT_DLOCK = 1;
    localparam int BIT_MDIX  = 2;
    localparam int BIT_IRQ   = 3;
    localparam int BIT_PAGE  = 4;
    localparam int BIT_POL   = 5;
    localparam int BIT_RXERR = 6;
    localparam int BIT_FCAR  = 7;

    // Field layout, most significant first, matching the positions above
    typedef struct packed {
        logic fcar;
        logic rxerr;
        logic pol;
        logic page;
        logic irq;
        logic mdix;
        logic dlock;
        logic sdq;
    } stat_fields_t;
endpackage

// File: rtl/xstat_sticky_bit.sv
// Module: one sticky event flag. A set pulse forces it high, and a clear pulse from the
// owning register's read drops it. A set pulse wins over a clear pulse in the same cycle,
// so no event is lost.
// Assumes both pulses are single-cycle and synchronous to clk.
module xstat_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic q
);
    // Purpose: set-dominant sticky flag with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else
            q <= set_pulse | (q & ~clr_pulse);
    end

    // An event always leaves the flag set, even beside a clearing read
    assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> q);

    // The owner's read with no new event clears the flag (covers each sticky requirement, e.g. R2)
    assert_owner_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !set_pulse) |=> !q);

    // With neither pulse, nothing else (including an aggregate read) moves the flag
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_pulse && !clr_pulse) |=> (q == $past(q)));
endmodule

// File: rtl/xstat_sd_qualify.sv
// Module: qualified signal-detect. Passes raw detect, optionally gated by descrambler lock.
// Assumes the inputs are already synchronous levels; the output is combinational.
module xstat_sd_qualify (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_sd,
    input  logic descr_lock,
    input  logic sd_qual_en,
    output logic sigdet_q
);
    // Purpose: gate raw detect with lock only while qualification is enabled
    always_comb begin
        sigdet_q = raw_sd & (descr_lock | ~sd_qual_en);
    end

    // Detect never asserts without raw detect
    assert_sd_needs_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_sd |-> !sigdet_q);

    // While qualifying, missing lock suppresses detect
    assert_sd_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_qual_en && !descr_lock) |-> !sigdet_q);
endmodule

// File: rtl/xstat_word_pack.sv
// Module: assembles the aggregate word from sticky flags and levels, and captures it
// into the read-data register on an aggregate read strobe.
// Assumes STAT_W >= USED_BITS. The capture uses pre-edge flag values, so a read
// returns the state held just before any clear at that same edge.
module xstat_word_pack
    import xstat_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_strobe,
    input  logic [NUM_LATCH-1:0] lat_q,
    input  logic                 sdq,
    input  logic                 dlock,
    input  logic                 mdix,
    output logic [STAT_W-1:0]    rd_data
);
    stat_fields_t        fields;
    logic [STAT_W-1:0]   word;

    // Purpose: map each source onto its field of the word
    always_comb begin
        fields       = '0;
        fields.sdq   = sdq;
        fields.dlock = dlock;
        fields.mdix  = mdix;
        fields.irq   = lat_q[LAT_IRQ];
        fields.page  = lat_q[LAT_PAGE];
        fields.pol   = lat_q[LAT_POL];
        fields.rxerr = lat_q[LAT_RXERR];
        fields.fcar  = lat_q[LAT_FCAR];
    end

    // Purpose: zero-extend the fields into the full-width word (reserved bits stay 0)
    always_comb begin
        word                = '0;
        word[USED_BITS-1:0] = fields;
    end

    // Purpose: capture the word on an aggregate read, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_strobe)
            rd_data <= word;
    end

    // Captured data only moves on an aggregate read
    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));

    generate
        if (STAT_W > USED_BITS) begin : g_resv
            // Reserved upper bits never read as anything but zero
            assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
                rd_data[STAT_W-1:USED_BITS] == '0);
        end
    endgenerate
endmodule

// File: rtl/xcvr_status_agg.sv
// Module: top of the aggregate status register. It holds one sticky flag per latched
// event source, each cleared by its own owner-register read strobe, plus the
// signal-detect qualifier and the word capture.
// Assumes all strobes and event pulses are single-cycle and synchronous to clk, and
// that reset is synchronous and active low.
module xcvr_status_agg
    import xstat_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_err_evt,
    input  logic              false_carr_evt,
    input  logic              pol_inv_evt,
    input  logic              page_rx_evt,
    input  logic              irq_evt,
    input  logic              rd_rxerr_cnt,
    input  logic              rd_fcar_cnt,
    input  logic              rd_tenbt_stat,
    input  logic              rd_an_exp,
    input  logic              rd_irq_stat,
    input  logic              rd_agg,
    input  logic              raw_sd,
    input  logic              descr_lock,
    input  logic              sd_qual_en,
    input  logic              mdix_swapped,
    output logic              sigdet_q,
    output logic [STAT_W-1:0] rd_data
);
    logic [NUM_LATCH-1:0] evt_v;
    logic [NUM_LATCH-1:0] clr_v;
    logic [NUM_LATCH-1:0] lat_q;

    // Purpose: gather event pulses and owner-read strobes into index-aligned vectors
    always_comb begin
        evt_v            = '0;
        clr_v            = '0;
        evt_v[LAT_RXERR] = rx_err_evt;
        evt_v[LAT_FCAR]  = false_carr_evt;
        evt_v[LAT_POL]   = pol_inv_evt;
        evt_v[LAT_PAGE]  = page_rx_evt;
        evt_v[LAT_IRQ]   = irq_evt;
        clr_v[LAT_RXERR] = rd_rxerr_cnt;
        clr_v[LAT_FCAR]  = rd_fcar_cnt;
        clr_v[LAT_POL]   = rd_tenbt_stat;
        clr_v[LAT_PAGE]  = rd_an_exp;
        clr_v[LAT_IRQ]   = rd_irq_stat;
    end

    generate
        for (genvar g = 0; g < NUM_LATCH; g++) begin : g_lat
            xstat_sticky_bit u_lat (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_pulse (evt_v[g]),
                .clr_pulse (clr_v[g]),
                .q         (lat_q[g])
            );
        end
    endgenerate

    xstat_sd_qualify u_sdq (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_sd     (raw_sd),
        .descr_lock (descr_lock),
        .sd_qual_en (sd_qual_en),
        .sigdet_q   (sigdet_q)
    );

    xstat_word_pack #(.STAT_W(STAT_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_agg),
        .lat_q     (lat_q),
        .sdq       (sigdet_q),
        .dlock     (descr_lock),
        .mdix      (mdix_swapped),
        .rd_data   (rd_data)
    );

    // A read that coincides with the receive-error clear still reports the set flag
    assert_read_preclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_agg && rd_rxerr_cnt && lat_q[LAT_RXERR]) |=> rd_data[BIT_RXERR]);
endmodule

// File: tb/xcvr_status_agg_bench.sv
module xcvr_status_agg_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] ev = '0;   // rxerr, fcar, pol, page, irq
    logic [4:0] cl = '0;
    logic rdA = 1'b0;
    logic raw = 1'b0, lock = 1'b0, en = 1'b0, mx = 1'b0;
    logic sigdet_q;
    logic [15:0] rd_data;

    int n_vec = 0;
    int n_err = 0;
    logic [4:0]  m_lat = '0;
    logic [15:0] m_rd  = '0;

    always #10 clk = ~clk;

    xcvr_status_agg u_xcvr_status_agg (
        .clk(clk), .rst_n(rst_n),
        .rx_err_evt(ev[0]), .false_carr_evt(ev[1]), .pol_inv_evt(ev[2]),
        .page_rx_evt(ev[3]), .irq_evt(ev[4]),
        .rd_rxerr_cnt(cl[0]), .rd_fcar_cnt(cl[1]), .rd_tenbt_stat(cl[2]),
        .rd_an_exp(cl[3]), .rd_irq_stat(cl[4]), .rd_agg(rdA),
        .raw_sd(raw), .descr_lock(lock), .sd_qual_en(en), .mdix_swapped(mx),
        .sigdet_q(sigdet_q), .rd_data(rd_data)
    );

    function automatic logic sd_exp(logic r, logic k, logic e);
        return r & (k | ~e);
    endfunction

    function automatic logic [15:0] pack_exp(logic [4:0] l, logic s, logic k, logic m);
        return {8'h00, l[1], l[0], l[2], l[3], l[4], m, k, s};
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // One clock: update the model at the edge, return at the following negedge
    task automatic cycle();
        @(posedge clk);
        if (!rst_n) begin
            m_lat = '0;
            m_rd  = '0;
        end else begin
            if (rdA) m_rd = pack_exp(m_lat, sd_exp(raw, lock, en), lock, mx);
            m_lat = ev | (m_lat & ~cl);
        end
        @(negedge clk);
    endtask

    task automatic pulse(input logic [4:0] e, input logic [4:0] c, input logic r);
        ev = e; cl = c; rdA = r;
        cycle();
        ev = '0; cl = '0; rdA = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        int pos[5];
        string tg[5];
        logic [15:0] held;
        pos = '{6, 7, 5, 4, 3};
        tg  = '{"R2", "R3", "R4", "R5", "R6"};
        void'($urandom(32'h5EED_1234));

        @(negedge clk);
        repeat (3) cycle();
        chk("R1 reset rd_data", rd_data, 16'h0000);
        chk("R1 reset sigdet_q", {15'b0, sigdet_q}, 16'h0000);
        rst_n = 1'b1;
        pulse('0, '0, 1'b1);
        chk("R1 first read", rd_data, 16'h0000);

        // Per-source set, hold across reads, foreign strobes, owner clear
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i), '0, 1'b0);
            pulse('0, '0, 1'b1);
            chk({tg[i], " set by event"}, {15'b0, rd_data[pos[i]]}, 16'h1);
            pulse('0, '0, 1'b1);
            chk("R7 aggregate read keeps bit", {15'b0, rd_data[pos[i]]}, 16'h1);
            pulse('0, 5'h1f & ~5'(1 << i), 1'b0);
            pulse('0, '0, 1'b1);
            chk("R7 foreign strobe keeps bit", {15'b0, rd_data[pos[i]]}, 16'h1);
            pulse('0, 5'(1 << i), 1'b0);
            pulse('0, '0, 1'b1);
            chk({tg[i], " cleared by owner read"}, {15'b0, rd_data[pos[i]]}, 16'h0);
        end

        // Event and clearing read together: bit stays set
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i), 5'(1 << i), 1'b0);
            pulse('0, '0, 1'b1);
            chk("R8 event beats clear", {15'b0, rd_data[pos[i]]}, 16'h1);
            pulse('0, 5'(1 << i), 1'b0);
        end

        // Aggregate read with clear in the same cycle returns the pre-clear value
        pulse(5'b00001, '0, 1'b0);
        pulse('0, 5'b00001, 1'b1);
        chk("R9 read beside clear", {15'b0, rd_data[6]}, 16'h1);
        pulse('0, '0, 1'b1);
        chk("R9 following read", {15'b0, rd_data[6]}, 16'h0);

        // Detect qualification over all input combinations
        for (int c = 0; c < 8; c++) begin
            raw = c[0]; lock = c[1]; en = c[2];
            #1;
            chk("R10 sigdet_q", {15'b0, sigdet_q}, {15'b0, sd_exp(raw, lock, en)});
            pulse('0, '0, 1'b1);
            chk("R10 word bit0", {15'b0, rd_data[0]}, {15'b0, sd_exp(raw, lock, en)});
            chk("R11 word bit1 lock", {15'b0, rd_data[1]}, {15'b0, lock});
        end

        mx = 1'b1;
        pulse('0, '0, 1'b1);
        chk("R11 mdix swapped", {15'b0, rd_data[2]}, 16'h1);
        mx = 1'b0;
        pulse('0, '0, 1'b1);
        chk("R11 mdix normal", {15'b0, rd_data[2]}, 16'h0);

        // Everything high: reserved bits remain zero
        raw = 1'b1; lock = 1'b1; en = 1'b1; mx = 1'b1;
        pulse(5'h1f, '0, 1'b0);
        pulse('0, '0, 1'b1);
        chk("R12 full word", rd_data, 16'h00FF);

        // Without an aggregate read the captured word does not move
        held = rd_data;
        raw = 1'b0; mx = 1'b0;
        pulse(5'h1f, 5'h1f, 1'b0);
        pulse('0, 5'h1f, 1'b0);
        chk("R13 hold without read", rd_data, held);
        pulse('0, '0, 1'b1);
        chk("R13 read after clears", rd_data, 16'h0002);

        // Random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            ev   = 5'($urandom) & 5'($urandom) & 5'($urandom);
            cl   = 5'($urandom) & 5'($urandom);
            rdA  = 1'($urandom);
            raw  = 1'($urandom);
            lock = 1'($urandom);
            en   = 1'($urandom);
            mx   = 1'($urandom);
            #1;
            chk("R10 random sigdet_q", {15'b0, sigdet_q}, {15'b0, sd_exp(raw, lock, en)});
            cycle();
            chk("R13 random rd_data", rd_data, m_rd);
        end
        ev = '0; cl = '0; rdA = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule